// File: doc/BRIEF.md
# Horizontal Slot Timing Generator

This block produces the per-line memory access slot count for a tile-based video display processor. A slot clock enable advances an 8-bit counter that nominally spans 0x00 to 0xFF but skips a run of values that depends on the horizontal mode. This gives 171 slots per line in the narrow mode and 210 in the wide mode. From the counter value the block derives a horizontal interrupt pulse, the horizontal blanking level, a refresh-slot flag and a strobe that marks the slots in which an external agent may access video memory.

While the display is active, only a sparse fixed set of slots grants external access. While the display is blanked, every slot except the refresh slots grants it. A rising edge on the latch strobe captures the current slot count together with an externally supplied line counter. A mode change requested mid-line is held off until the counter wraps, so no line mixes the two skip rules.

Top module: `hslot_timing_gen`

## Requirements
- R1: In narrow mode (wide_mode=0) the count runs 0x00..0x93, then continues at 0xE9 and runs to 0xFF, then wraps to 0x00, so a line has 171 slots.
- R2: In wide mode (wide_mode=1) the count runs 0x00..0xB6, then continues at 0xE5 and runs to 0xFF, then wraps to 0x00, so a line has 210 slots.
- R3: After synchronous reset, slot_count is 0x00, the mode is narrow, hblank is 1 and every other output is 0. The count advances only at a clock edge where slot_ce is 1, and otherwise holds. Every output is registered and shows the effect of a slot_ce at the following edge.
- R4: wide_mode is sampled only when the count wraps from 0xFF to 0x00, and it then governs the whole following line.
- R5: hint_pulse is high for exactly the one cycle after the count enters 0x85 (narrow) or 0xA5 (wide).
- R6: hblank is 1 while the count is at least 0x93 or below 0x05 (narrow), or at least 0xB4 or below 0x06 (wide), and 0 otherwise.
- R7: With disp_active=1 in narrow mode, access_stb pulses for one cycle when the count enters any of the decimal slots 2, 10, 18, 34, 42, 50, 66, 74, 82, 98, 106, 114, 129, 130, 145, 243, and for no other slot.
- R8: With disp_active=1 in wide mode, access_stb pulses for one cycle when the count enters any of the decimal slots 2, 10, 18, 34, 42, 50, 66, 74, 82, 98, 106, 114, 130, 138, 146, 161, 162, 232, and for no other slot.
- R9: refresh_slot is 1 while the count is one of the decimal slots 26, 58, 90, 122, 250, or additionally 154 in wide mode. access_stb never pulses on a refresh slot.
- R10: With disp_active=0, access_stb pulses for one cycle on entry to every slot that is not a refresh slot.
- R11: On a 0-to-1 transition of latch_strobe, hv_latch takes vline in bits 15:8 and the slot count held before that edge in bits 7:0, visible after the edge. A strobe held high does not capture again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_ce | input | 1 | Slot clock enable, one per slot advance |
| wide_mode | input | 1 | Mode request: 0 narrow (171 slots), 1 wide (210 slots) |
| disp_active | input | 1 | 1 while the display is active, 0 while blanked |
| latch_strobe | input | 1 | Counter capture request, acts on its rising edge |
| vline | input | 8 | Vertical line counter from outside |
| slot_count | output | 8 | Current slot count |
| access_stb | output | 1 | One-cycle external access slot strobe |
| refresh_slot | output | 1 | Current slot is a refresh slot |
| hint_pulse | output | 1 | One-cycle horizontal interrupt pulse |
| hblank | output | 1 | Horizontal blanking level |
| hv_latch | output | 16 | Captured {vline, slot_count} |

## Verification
Every output of this block is due exactly one clock after the input cycle that causes it: a slot_ce changes slot_count and the slot flags at the next rising edge, and a latch edge updates hv_latch at that same edge. The bench drives inputs on the falling edge and records the expected outputs for that cycle. A monitor compares them 5 ns after the following rising edge, so each comparison sits one register stage after its stimulus. Line lengths are measured from the visible count by the number of enabled cycles between successive 0x00 values.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  localparam int SLOT_W = 8;
  localparam int VCNT_W = 8;
  localparam int HV_W   = SLOT_W + VCNT_W;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic access;
    logic refresh;
    logic hint;
    logic hblank;
  } slot_flags_t;

  localparam slot_t SLOT_MAX = '1;

  function automatic slot_t gap_last(input logic wide);
    return wide ? slot_t'(8'hB6) : slot_t'(8'h93);
  endfunction

  function automatic slot_t gap_resume(input logic wide);
    return wide ? slot_t'(8'hE5) : slot_t'(8'hE9);
  endfunction

  function automatic slot_t hint_slot(input logic wide);
    return wide ? slot_t'(8'hA5) : slot_t'(8'h85);
  endfunction

  function automatic logic in_hblank(input slot_t n, input logic wide);
    if (wide) return (n >= slot_t'(8'hB4)) || (n < slot_t'(8'h06));
    else      return (n >= slot_t'(8'h93)) || (n < slot_t'(8'h05));
  endfunction

  // refresh every 32 slots from 26 up to 122 (154 only reachable in wide), plus 250
  function automatic logic is_refresh(input slot_t n, input logic wide);
    logic periodic;
    periodic = (n[4:0] == 5'd26) &&
               ((n < slot_t'(154)) || (wide && (n == slot_t'(154))));
    return periodic || (n == slot_t'(250));
  endfunction

  // external access slots while the display is active
  function automatic logic is_active_access(input slot_t n, input logic wide);
    logic base;
    base = (n < slot_t'(128)) &&
           ((n[4:0] == 5'd2) || (n[4:0] == 5'd10) || (n[4:0] == 5'd18));
    if (wide)
      return base || (n inside {slot_t'(130), slot_t'(138), slot_t'(146),
                                slot_t'(161), slot_t'(162), slot_t'(232)});
    else
      return base || (n inside {slot_t'(129), slot_t'(130), slot_t'(145),
                                slot_t'(243)});
  endfunction
endpackage

// File: rtl/hsg_counter.sv
module hsg_counter
  import hsg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ce,
  input  logic  wide_req,
  output slot_t cnt_q,
  output logic  wide_q,
  output slot_t cnt_nxt,
  output logic  wide_nxt
);
  always_comb begin
    cnt_nxt  = cnt_q;
    wide_nxt = wide_q;
    if (ce) begin
      if (cnt_q == SLOT_MAX) begin
        cnt_nxt  = '0;
        wide_nxt = wide_req;
      end else if (cnt_q == gap_last(wide_q)) begin
        cnt_nxt = gap_resume(wide_q);
      end else begin
        cnt_nxt = cnt_q + slot_t'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      wide_q <= wide_nxt;
    end
  end
endmodule

// File: rtl/hsg_decode.sv
module hsg_decode
  import hsg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ce,
  input  logic        disp_active,
  input  slot_t       cnt_nxt,
  input  logic        wide_nxt,
  output slot_flags_t flags_q
);
  slot_flags_t flags_d;

  always_comb begin
    flags_d.refresh = is_refresh(cnt_nxt, wide_nxt);
    flags_d.hblank  = in_hblank(cnt_nxt, wide_nxt);
    flags_d.hint    = ce && (cnt_nxt == hint_slot(wide_nxt));
    if (disp_active)
      flags_d.access = ce && is_active_access(cnt_nxt, wide_nxt);
    else
      flags_d.access = ce && !flags_d.refresh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q         <= '0;
      flags_q.hblank  <= 1'b1;
    end else begin
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/hsg_latch.sv
module hsg_latch
  import hsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  slot_t             slot,
  input  logic [VCNT_W-1:0] vline,
  output logic [HV_W-1:0]   hv_q
);
  logic strobe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_d <= 1'b0;
      hv_q     <= '0;
    end else begin
      strobe_d <= strobe;
      if (strobe && !strobe_d)
        hv_q <= {vline, slot};
    end
  end
endmodule

// File: rtl/hslot_timing_gen.sv
module hslot_timing_gen
  import hsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_ce,
  input  logic              wide_mode,
  input  logic              disp_active,
  input  logic              latch_strobe,
  input  logic [VCNT_W-1:0] vline,
  output logic [SLOT_W-1:0] slot_count,
  output logic              access_stb,
  output logic              refresh_slot,
  output logic              hint_pulse,
  output logic              hblank,
  output logic [HV_W-1:0]   hv_latch
);
  slot_t       cnt_q, cnt_nxt;
  logic        line_wide, wide_nxt;
  slot_flags_t flags;

  hsg_counter u_cnt (
    .clk(clk), .rst(rst), .ce(slot_ce), .wide_req(wide_mode),
    .cnt_q(cnt_q), .wide_q(line_wide), .cnt_nxt(cnt_nxt), .wide_nxt(wide_nxt)
  );

  hsg_decode u_dec (
    .clk(clk), .rst(rst), .ce(slot_ce), .disp_active(disp_active),
    .cnt_nxt(cnt_nxt), .wide_nxt(wide_nxt), .flags_q(flags)
  );

  hsg_latch u_lat (
    .clk(clk), .rst(rst), .strobe(latch_strobe), .slot(cnt_q),
    .vline(vline), .hv_q(hv_latch)
  );

  assign slot_count   = cnt_q;
  assign access_stb   = flags.access;
  assign refresh_slot = flags.refresh;
  assign hint_pulse   = flags.hint;
  assign hblank       = flags.hblank;
endmodule

// File: rtl/hsg_checker.sv
module hsg_checker (
  input logic       clk,
  input logic       rst,
  input logic       slot_ce,
  input logic       line_wide,
  input logic [7:0] slot_count,
  input logic       access_stb,
  input logic       refresh_slot,
  input logic       hint_pulse,
  input logic       hblank
);
  a_r1_narrow_jump: assert property (@(posedge clk) disable iff (rst)
    (slot_ce && !line_wide && slot_count == 8'h93) |=> slot_count == 8'hE9);

  a_r2_wide_jump: assert property (@(posedge clk) disable iff (rst)
    (slot_ce && line_wide && slot_count == 8'hB6) |=> slot_count == 8'hE5);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !slot_ce |=> $stable(slot_count));

  a_r4_mode_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_wide) |-> slot_count == 8'h00);

  a_r5_hint_slot: assert property (@(posedge clk) disable iff (rst)
    hint_pulse |-> slot_count == (line_wide ? 8'hA5 : 8'h85));

  a_r6_hblank_start: assert property (@(posedge clk) disable iff (rst)
    $rose(hblank) |-> slot_count == (line_wide ? 8'hB4 : 8'h93));

  a_r7_access_enabled: assert property (@(posedge clk) disable iff (rst)
    access_stb |-> $past(slot_ce));

  a_r9_no_access_refresh: assert property (@(posedge clk) disable iff (rst)
    access_stb |-> !refresh_slot);
endmodule

bind hslot_timing_gen hsg_checker u_chk (
  .clk(clk), .rst(rst), .slot_ce(slot_ce), .line_wide(line_wide),
  .slot_count(slot_count), .access_stb(access_stb), .refresh_slot(refresh_slot),
  .hint_pulse(hint_pulse), .hblank(hblank)
);

// File: tb/hslot_timing_gen_test.sv
module hslot_timing_gen_test;
  logic clk = 1'b0;
  logic rst, slot_ce, wide_mode, disp_active, latch_strobe;
  logic [7:0] vline;
  logic [7:0] slot_count;
  logic access_stb, refresh_slot, hint_pulse, hblank;
  logic [15:0] hv_latch;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hslot_timing_gen uut (
    .clk(clk), .rst(rst), .slot_ce(slot_ce), .wide_mode(wide_mode),
    .disp_active(disp_active), .latch_strobe(latch_strobe), .vline(vline),
    .slot_count(slot_count), .access_stb(access_stb), .refresh_slot(refresh_slot),
    .hint_pulse(hint_pulse), .hblank(hblank), .hv_latch(hv_latch)
  );

  typedef struct {
    logic [7:0]  slot;
    logic        acc, rf, hint, hb;
    logic [15:0] hv;
    string       tslot, tacc;
  } exp_t;

  exp_t q[$];

  int acc_narrow[16] = '{2,10,18,34,42,50,66,74,82,98,106,114,129,130,145,243};
  int acc_wide[18]   = '{2,10,18,34,42,50,66,74,82,98,106,114,130,138,146,161,162,232};
  int ref_list[6]    = '{26,58,90,122,250,154};

  // reference state
  int m_cnt = 0;
  bit m_wide = 0;
  bit m_lprev = 0;
  logic [15:0] m_hv = '0;
  int last_len;

  function automatic bit m_ref(int n, bit w);
    for (int i = 0; i < 6; i++)
      if (ref_list[i] == n && (i < 5 || w)) return 1;
    return 0;
  endfunction

  function automatic bit m_acc(int n, bit w);
    if (w) begin
      for (int i = 0; i < 18; i++) if (acc_wide[i] == n) return 1;
    end else begin
      for (int i = 0; i < 16; i++) if (acc_narrow[i] == n) return 1;
    end
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of inputs and queues the outcome due after the next edge
  task automatic step(bit ce, bit r, bit w, bit a, bit l, logic [7:0] v);
    exp_t e;
    bit wrap;
    @(negedge clk);
    slot_ce = ce; rst = r; wide_mode = w; disp_active = a;
    latch_strobe = l; vline = v;
    wrap = 0;
    if (r) begin
      m_cnt = 0; m_wide = 0; m_lprev = 0; m_hv = '0;
      e.slot = 0; e.acc = 0; e.rf = 0; e.hint = 0; e.hb = 1; e.hv = 0;
      e.tslot = "R3"; e.tacc = "R3";
    end else begin
      if (l && !m_lprev) m_hv = {v, 8'(m_cnt)};
      m_lprev = l;
      if (ce) begin
        if (m_cnt == 255) begin m_cnt = 0; m_wide = w; wrap = 1; end
        else if (!m_wide && m_cnt == 'h93) m_cnt = 'hE9;
        else if (m_wide && m_cnt == 'hB6) m_cnt = 'hE5;
        else m_cnt++;
      end
      e.slot = 8'(m_cnt);
      e.rf   = m_ref(m_cnt, m_wide);
      e.acc  = ce && (a ? m_acc(m_cnt, m_wide) : !e.rf);
      e.hint = ce && (m_cnt == (m_wide ? 'hA5 : 'h85));
      e.hb   = m_wide ? (m_cnt >= 'hB4 || m_cnt < 'h06) : (m_cnt >= 'h93 || m_cnt < 'h05);
      e.hv   = m_hv;
      e.tslot = !ce ? "R3" : (wrap ? "R4" : (m_wide ? "R2" : "R1"));
      e.tacc  = !a ? "R10" : (m_wide ? "R8" : "R7");
    end
    q.push_back(e);
  endtask

  // monitor: compares one queued item per cycle, 5 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tslot, "slot_count", slot_count, e.slot);
        check(e.tacc, "access_stb", access_stb, e.acc);
        check("R9", "refresh_slot", refresh_slot, e.rf);
        check("R5", "hint_pulse", hint_pulse, e.hint);
        check("R6", "hblank", hblank, e.hb);
        check("R11", "hv_latch", hv_latch, e.hv);
      end
    end
  end

  // run n cycles; slot_ce every div cycles; latch held 3 cycles every lat_per cycles
  task automatic run(int n, int div, bit w, bit a, int lat_per);
    int z0 = -1;
    logic [7:0] prev = 8'hFF;
    last_len = -1;
    for (int i = 0; i < n; i++) begin
      step((i % div) == 0, 0, w, a, (lat_per > 0) && ((i % lat_per) < 3), 8'(i) ^ 8'h5A);
      if (slot_count == 8'h00 && prev != 8'h00) begin
        if (z0 >= 0) last_len = i - z0;
        z0 = i;
      end
      prev = slot_count;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    slot_ce = 0; rst = 1; wide_mode = 0; disp_active = 1; latch_strobe = 0; vline = 0;
    // R3 reset state
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, 8'h00);
    // R1 narrow line, active display
    run(400, 1, 0, 1, 0);
    check("R1", "narrow line length", last_len, 171);
    // R10 blanked, R11 latches held high
    run(400, 1, 0, 0, 37);
    // R3 slot_ce gaps
    run(600, 3, 0, 1, 53);
    // R4 wide requested mid-line, applied at wrap
    run(90, 1, 1, 1, 0);
    run(500, 1, 1, 1, 0);
    check("R2", "wide line length", last_len, 210);
    run(500, 1, 1, 0, 23);
    run(900, 4, 1, 1, 61);
    // R4 back to narrow
    run(300, 1, 0, 1, 0);
    run(400, 1, 0, 1, 0);
    check("R4", "narrow length after mode return", last_len, 171);
    // R3 reset in mid line
    for (int i = 0; i < 2; i++) step(0, 1, 1, 1, 0, 8'h00);
    run(300, 1, 1, 1, 0);
    run(20, 1, 0, 1, 0);
    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule